// File: doc/BRIEF.md
# ADC Bring-up and Conversion Sequencer

This block is the controller that sits above a serial command engine attached to a multi-channel delta-sigma ADC. On a bring-up request it takes the converter from reset to a calibrated, programmed state. It resets the device and waits for the device to recover. It then leaves the power-up continuous-read mode and programs the data rate, the reference and every channel's gain, input mux and power-down state. Each register is written by a read-modify-write pass, so bits the block does not own keep their values. Bring-up ends by requesting offset calibration and running one start, wait and stop pass, which takes up the calibration delay.

Once bring-up is done, each conversion request starts the converter and waits for a falling edge on the active-low data-ready pin, with a timeout. It then reads one frame and stops the converter. The frame length in bytes is presented as an output. It depends on the data rate latched at bring-up and on the channel count. All waits come from one shared timer. Long waits are counted in ticks of a prescaler, so simulation can shorten them. Byte shifting on the serial bus is handled by the command engine and is not part of this block.

Top module: `adc_bringup_seq`

## Requirements
- R1: After reset, cmd_req, init_done, conv_done and err are all low.
- R2: The command interface carries cmd_op (0 = single command byte in cmd_code, 1 = register read with cmd_code = 0x20 + address, 2 = register write with cmd_code = 0x40 + address and data in cmd_wdata, 3 = frame read with cmd_code = 0x12 and byte count in cmd_len). One request is outstanding until cmd_done. Bring-up issues, in this order: 0x06, 0x11, read then write of 0x01, read then write of 0x03, read then write of 0x05+i for each channel i from 0 upward, 0x1A, 0x08, 0x0A.
- R3: After the reset command completes, at least RST_CYC clock cycles pass before the next command is requested.
- R4: The write to register 0x01 holds rate_code in bits [2:0] and keeps bits [7:3] as read.
- R5: The write to register 0x03 keeps bits [6], [4:0] as read. With ref_ext low it sets bit 7 and puts ref_4v in bit 5. With ref_ext high it clears bit 7 and keeps bit 5 as read.
- R6: The write to register 0x05+i holds that channel's gain code in bits [6:4] and mux code in bits [2:0], and keeps bit 3 as read. Bit 7 is set when ch_en[i] is clear and kept as read otherwise.
- R7: Between completion of the calibration start (0x08) and the request of the following stop (0x0A), at least CAL_TICKS*TICK_CYC cycles pass. init_done goes high after that stop completes.
- R8: frame_len equals 3 + 2*NCH when the latched rate code is 0 or 1, and 3 + 3*NCH for codes 2 to 6.
- R9: On a bring-up request with any gain code outside {1,2,4,5,6}, any mux code outside {0,1,3,4}, or rate_code 7, err is set, init_done is low and no command is issued.
- R10: A conversion request while init_done is low is ignored: no command is issued.
- R11: A conversion issues 0x08, waits for a falling data-ready edge, issues a frame read of frame_len bytes, issues 0x0A, then pulses conv_done for one cycle and clears err.
- R12: If no falling data-ready edge arrives within TMO_TICKS*TICK_CYC cycles after the start completes, err is set, no frame read is issued, and the block accepts the next conversion request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_req | input | 1 | Start bring-up (one-cycle pulse, accepted when idle) |
| conv_req | input | 1 | Start one conversion (accepted when idle and initialised) |
| ch_en | input | NCH | Channel enable mask; clear bits get powered down |
| ch_gain | input | 3*NCH | Gain code per channel, channel i in bits [3i+2:3i] |
| ch_mux | input | 3*NCH | Mux code per channel, channel i in bits [3i+2:3i] |
| rate_code | input | 3 | Data-rate code, 0 = fastest, 6 = slowest |
| ref_ext | input | 1 | High when an external reference is used |
| ref_4v | input | 1 | Internal reference select: 1 = 4 V, 0 = 2.4 V |
| drdy_n | input | 1 | Active-low data-ready from the ADC (asynchronous) |
| cmd_req | output | 1 | Request a command from the engine (one cycle) |
| cmd_op | output | 2 | Command kind, see R2 |
| cmd_code | output | 8 | Command or register opcode byte |
| cmd_wdata | output | 8 | Register write data |
| cmd_len | output | LENW | Frame read byte count |
| cmd_done | input | 1 | Engine finished the outstanding command |
| cmd_rdata | input | 8 | Register read data, valid with cmd_done |
| init_done | output | 1 | Bring-up complete |
| conv_done | output | 1 | One-cycle pulse after a completed conversion |
| err | output | 1 | Invalid configuration or data-ready timeout |
| frame_len | output | LENW | Bytes per data frame |

## Verification
The bench builds the block with four channels, an 18-cycle reset wait, a 4-cycle tick and waits of 5 and 6 ticks. With these values full bring-ups, calibration waits and data-ready timeouts each last a few dozen cycles, so many random configurations fit in one run. A model of the command engine with a small register file, random response latency and a scheduled data-ready pulse lets the bench check the written register values, the command order and the gaps between commands. Both frame-length formulas and the external and internal reference paths are reached through the directed cases and the random cases together.

// File: rtl/adc_seq_pkg.sv
// Package: shared types, command encodings and code validity helpers for
// the ADC bring-up sequencer. Assumes 3-bit gain, mux and rate codes.
package adc_seq_pkg;

    typedef enum logic [1:0] {
        OP_CMD   = 2'd0,
        OP_RREG  = 2'd1,
        OP_WREG  = 2'd2,
        OP_FRAME = 2'd3
    } cmd_op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_RST, S_RST_W, S_SDATAC, S_RREG, S_WREG, S_OCAL,
        S_CSTART, S_CWAIT, S_CSTOP, S_VSTART, S_VWAIT, S_VREAD, S_VSTOP
    } seq_state_e;

    localparam logic [7:0] OPC_RESET = 8'h06;
    localparam logic [7:0] OPC_START = 8'h08;
    localparam logic [7:0] OPC_STOP  = 8'h0A;
    localparam logic [7:0] OPC_OCAL  = 8'h1A;
    localparam logic [7:0] OPC_NOCNT = 8'h11;
    localparam logic [7:0] OPC_FRAME = 8'h12;
    localparam logic [7:0] OPC_RREG  = 8'h20;
    localparam logic [7:0] OPC_WREG  = 8'h40;
    localparam logic [2:0] RATE_MAX  = 3'd6;

    function automatic logic gain_code_ok(input logic [2:0] g);
        return g inside {3'd1, 3'd2, 3'd4, 3'd5, 3'd6};
    endfunction

    function automatic logic mux_code_ok(input logic [2:0] m);
        return m inside {3'd0, 3'd1, 3'd3, 3'd4};
    endfunction

endpackage

// File: rtl/adc_cfg_check.sv
// Configuration checker: flags any illegal gain, mux or rate code, and
// computes the frame length for the latched rate. Purely combinational.
// Assumes codes 0 and 1 are the two fast rates that use 2-byte samples.
module adc_cfg_check
    import adc_seq_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int LENW = 5
) (
    input  logic [3*NCH-1:0] ch_gain,
    input  logic [3*NCH-1:0] ch_mux,
    input  logic [2:0]       rate_code,
    input  logic [2:0]       rate_sel,
    output logic             cfg_ok,
    output logic [LENW-1:0]  frame_len
);
    localparam logic [LENW-1:0] LEN_SHORT = LENW'(3 + 2 * NCH);
    localparam logic [LENW-1:0] LEN_LONG  = LENW'(3 + 3 * NCH);

    logic [NCH-1:0] ch_ok;

    // Per-channel legality of the gain and mux codes
    for (genvar g = 0; g < NCH; g++) begin : g_chk
        assign ch_ok[g] = gain_code_ok(ch_gain[3*g +: 3]) && mux_code_ok(ch_mux[3*g +: 3]);
    end

    // Whole configuration is usable only if every channel and the rate are legal
    assign cfg_ok = (&ch_ok) && (rate_code <= RATE_MAX);

    // Sample width follows the latched rate
    assign frame_len = (rate_sel <= 3'd1) ? LEN_SHORT : LEN_LONG;

endmodule

// File: rtl/adc_wait_timer.sv
// Shared wait timer: after start it counts count units and pulses done for
// one cycle. A unit is one clock, or one tick of TICK_CYC clocks when
// use_tick is set. A new start restarts it. Assumes count is at least 1.
module adc_wait_timer #(
    parameter int CW       = 8,
    parameter int TICK_CYC = 125000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          use_tick,
    input  logic [CW-1:0] count,
    output logic          done
);
    localparam int PW = $clog2(TICK_CYC + 1);
    localparam logic [PW-1:0] PRE_LAST = PW'(TICK_CYC - 1);

    logic          busy;
    logic          tick_mode;
    logic [CW-1:0] cnt;
    logic [PW-1:0] pre;
    logic          step;

    assign step = !tick_mode || (pre == PRE_LAST);

    // Prescaler and unit down-counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            tick_mode <= 1'b0;
            cnt       <= '0;
            pre       <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy      <= 1'b1;
                tick_mode <= use_tick;
                cnt       <= count;
                pre       <= '0;
            end else if (busy) begin
                pre <= (pre == PRE_LAST) ? '0 : pre + 1'b1;
                if (step) begin
                    if (cnt <= 1) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            end
        end
    end

    AST_TIMER_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (count != '0));  // R3

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));  // R7

endmodule

// File: rtl/adc_bringup_seq.sv
// ADC bring-up and conversion sequencer. It drives a command engine through
// reset, continuous-read exit, read-modify-write of rate, reference and
// channel registers, offset calibration and a start-wait-stop pass. After
// that it runs single conversions gated by data-ready with a timeout.
// Assumes configuration inputs stay stable from init_req until init_done,
// the engine raises cmd_done once per cmd_req, and NCH is at most 26.
module adc_bringup_seq
    import adc_seq_pkg::*;
#(
    parameter int NCH       = 8,
    parameter int RST_CYC   = 36,
    parameter int TICK_CYC  = 125000,
    parameter int CAL_TICKS = 153,
    parameter int TMO_TICKS = 6,
    localparam int LENW     = $clog2(3 + 3 * NCH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_req,
    input  logic             conv_req,
    input  logic [NCH-1:0]   ch_en,
    input  logic [3*NCH-1:0] ch_gain,
    input  logic [3*NCH-1:0] ch_mux,
    input  logic [2:0]       rate_code,
    input  logic             ref_ext,
    input  logic             ref_4v,
    input  logic             drdy_n,
    output logic             cmd_req,
    output logic [1:0]       cmd_op,
    output logic [7:0]       cmd_code,
    output logic [7:0]       cmd_wdata,
    output logic [LENW-1:0]  cmd_len,
    input  logic             cmd_done,
    input  logic [7:0]       cmd_rdata,
    output logic             init_done,
    output logic             conv_done,
    output logic             err,
    output logic [LENW-1:0]  frame_len
);
    localparam int IW   = $clog2(NCH + 2);
    localparam int LAST = NCH + 1;
    localparam int MAXC = (RST_CYC > CAL_TICKS) ?
                          ((RST_CYC > TMO_TICKS) ? RST_CYC : TMO_TICKS) :
                          ((CAL_TICKS > TMO_TICKS) ? CAL_TICKS : TMO_TICKS);
    localparam int CW   = $clog2(MAXC + 1);

    seq_state_e    state;
    logic [IW-1:0] idx;
    logic [IW-1:0] ch_sel;
    logic [7:0]    rd_q;
    logic [2:0]    rate_r;
    logic          pending, init_ok, err_q, conv_done_q;
    logic [2:0]    drdy_s;
    logic          fall;
    logic          is_cmd, cmd_fire, cfg_ok;
    logic          tmr_start, tmr_tick, tmr_done;
    logic [CW-1:0] tmr_count;
    logic [4:0]    reg_addr;
    cmd_op_e       op;
    logic [2:0]    sel_gain, sel_mux;

    adc_cfg_check #(.NCH(NCH), .LENW(LENW)) u_cfg (
        .ch_gain(ch_gain), .ch_mux(ch_mux), .rate_code(rate_code),
        .rate_sel(rate_r), .cfg_ok(cfg_ok), .frame_len(frame_len)
    );

    adc_wait_timer #(.CW(CW), .TICK_CYC(TICK_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .use_tick(tmr_tick),
        .count(tmr_count), .done(tmr_done)
    );

    // Register address and channel selection for the read-modify-write walk
    assign ch_sel   = (idx >= IW'(2)) ? idx - IW'(2) : '0;
    assign reg_addr = (idx == '0) ? 5'd1 : (idx == IW'(1)) ? 5'd3 : 5'(idx) + 5'd3;
    assign sel_gain = ch_gain[3*ch_sel +: 3];
    assign sel_mux  = ch_mux[3*ch_sel +: 3];

    // Command kind, opcode byte and write data for the current state
    always_comb begin
        is_cmd    = 1'b1;
        op        = OP_CMD;
        cmd_code  = 8'h00;
        cmd_wdata = 8'h00;
        case (state)
            S_RST:    cmd_code = OPC_RESET;
            S_SDATAC: cmd_code = OPC_NOCNT;
            S_OCAL:   cmd_code = OPC_OCAL;
            S_CSTART, S_VSTART: cmd_code = OPC_START;
            S_CSTOP,  S_VSTOP:  cmd_code = OPC_STOP;
            S_RREG: begin
                op       = OP_RREG;
                cmd_code = OPC_RREG | {3'b000, reg_addr};
            end
            S_WREG: begin
                op       = OP_WREG;
                cmd_code = OPC_WREG | {3'b000, reg_addr};
                if (idx == '0)
                    cmd_wdata = {rd_q[7:3], rate_r};
                else if (idx == IW'(1))
                    cmd_wdata = ref_ext ? {1'b0, rd_q[6:0]} : {1'b1, rd_q[6], ref_4v, rd_q[4:0]};
                else
                    cmd_wdata = {rd_q[7] | ~ch_en[ch_sel], sel_gain, rd_q[3], sel_mux};
            end
            S_VREAD: begin
                op       = OP_FRAME;
                cmd_code = OPC_FRAME;
            end
            default: is_cmd = 1'b0;
        endcase
    end

    assign cmd_op    = op;
    assign cmd_len   = frame_len;
    assign cmd_req   = is_cmd && !pending;
    assign cmd_fire  = is_cmd && pending && cmd_done;
    assign init_done = init_ok;
    assign conv_done = conv_done_q;
    assign err       = err_q;
    assign fall      = drdy_s[2] & ~drdy_s[1];

    // Timer launch on completion of reset and of each start command
    always_comb begin
        tmr_start = cmd_fire && (state inside {S_RST, S_CSTART, S_VSTART});
        tmr_tick  = (state != S_RST);
        case (state)
            S_RST:    tmr_count = CW'(RST_CYC);
            S_CSTART: tmr_count = CW'(CAL_TICKS);
            default:  tmr_count = CW'(TMO_TICKS);
        endcase
    end

    // Outstanding-request flag: set on request, cleared on completion
    always_ff @(posedge clk) begin
        if (!rst_n)        pending <= 1'b0;
        else if (cmd_fire) pending <= 1'b0;
        else if (cmd_req)  pending <= 1'b1;
    end

    // Data-ready synchroniser and edge history
    always_ff @(posedge clk) begin
        if (!rst_n) drdy_s <= 3'b111;
        else        drdy_s <= {drdy_s[1:0], drdy_n};
    end

    // Sequencer state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            idx         <= '0;
            rd_q        <= '0;
            rate_r      <= RATE_MAX;
            init_ok     <= 1'b0;
            err_q       <= 1'b0;
            conv_done_q <= 1'b0;
        end else begin
            conv_done_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (init_req) begin
                        err_q   <= !cfg_ok;
                        init_ok <= 1'b0;
                        if (cfg_ok) begin
                            rate_r <= rate_code;
                            state  <= S_RST;
                        end
                    end else if (conv_req && init_ok) begin
                        err_q <= 1'b0;
                        state <= S_VSTART;
                    end
                end
                S_RST:    if (cmd_fire) state <= S_RST_W;
                S_RST_W:  if (tmr_done) state <= S_SDATAC;
                S_SDATAC: if (cmd_fire) begin
                    idx   <= '0;
                    state <= S_RREG;
                end
                S_RREG:   if (cmd_fire) begin
                    rd_q  <= cmd_rdata;
                    state <= S_WREG;
                end
                S_WREG:   if (cmd_fire) begin
                    if (idx == IW'(LAST)) begin
                        state <= S_OCAL;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= S_RREG;
                    end
                end
                S_OCAL:   if (cmd_fire) state <= S_CSTART;
                S_CSTART: if (cmd_fire) state <= S_CWAIT;
                S_CWAIT:  if (tmr_done) state <= S_CSTOP;
                S_CSTOP:  if (cmd_fire) begin
                    init_ok <= 1'b1;
                    state   <= S_IDLE;
                end
                S_VSTART: if (cmd_fire) state <= S_VWAIT;
                S_VWAIT: begin
                    if (fall) begin
                        state <= S_VREAD;
                    end else if (tmr_done) begin
                        err_q <= 1'b1;
                        state <= S_IDLE;
                    end
                end
                S_VREAD:  if (cmd_fire) state <= S_VSTOP;
                S_VSTOP:  if (cmd_fire) begin
                    conv_done_q <= 1'b1;
                    state       <= S_IDLE;
                end
                default:  state <= S_IDLE;
            endcase
        end
    end

    AST_BAD_CFG_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && init_req && !cfg_ok) |=> (err && !cmd_req && !init_done));  // R9

    AST_CONV_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && conv_req && !init_req && !init_done) |=> !cmd_req);  // R10

    AST_PWD_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && state == S_WREG && idx >= IW'(2) && !ch_en[ch_sel]) |-> cmd_wdata[7]);  // R6

    AST_FRAME_LEN_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_len == LENW'(3 + 2 * NCH)) || (frame_len == LENW'(3 + 3 * NCH)));  // R8

    AST_TIMEOUT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_VWAIT && tmr_done && !fall) |=> (err && state == S_IDLE));  // R12

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !conv_done);  // R11

endmodule

// File: tb/adc_bringup_seq_tb.sv
module adc_bringup_seq_tb;
    localparam int NCH = 4, RST_CYC = 18, TICK_CYC = 4, CAL_TICKS = 5, TMO_TICKS = 6;
    localparam int LENW = $clog2(3 + 3 * NCH + 1);

    logic clk = 1'b0, rst_n = 1'b0, init_req = 1'b0, conv_req = 1'b0;
    logic [NCH-1:0] ch_en = '1;
    logic [3*NCH-1:0] ch_gain = '0, ch_mux = '0;
    logic [2:0] rate_code = 3'd6;
    logic ref_ext = 1'b0, ref_4v = 1'b0, drdy_n = 1'b1;
    logic cmd_req, cmd_done = 1'b0, init_done, conv_done, err;
    logic [1:0] cmd_op;
    logic [7:0] cmd_code, cmd_wdata, cmd_rdata = 8'h00;
    logic [LENW-1:0] cmd_len, frame_len;

    adc_bringup_seq #(.NCH(NCH), .RST_CYC(RST_CYC), .TICK_CYC(TICK_CYC),
        .CAL_TICKS(CAL_TICKS), .TMO_TICKS(TMO_TICKS)) u_dut (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .conv_req(conv_req),
        .ch_en(ch_en), .ch_gain(ch_gain), .ch_mux(ch_mux), .rate_code(rate_code),
        .ref_ext(ref_ext), .ref_4v(ref_4v), .drdy_n(drdy_n), .cmd_req(cmd_req),
        .cmd_op(cmd_op), .cmd_code(cmd_code), .cmd_wdata(cmd_wdata), .cmd_len(cmd_len),
        .cmd_done(cmd_done), .cmd_rdata(cmd_rdata), .init_done(init_done),
        .conv_done(conv_done), .err(err), .frame_len(frame_len));

    always #4 clk = ~clk;

    int total = 0, fails = 0, cyc = 0, conv_cnt = 0;
    bit finished = 0;
    logic [7:0] regs [0:31];
    int log_n = 0;
    logic [7:0] log_code [0:63];
    int log_len [0:63];
    int log_t [0:63];
    int log_d [0:63];
    bit busy = 0, drdy_en = 0;
    int lat = 0, drdy_cnt = 0, low_cnt = 0;
    logic [1:0] c_op;
    logic [7:0] c_code, c_wd;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    // Command engine model with register file, random latency and data-ready scheduling
    always @(negedge clk) begin
        cyc++;
        if (conv_done) conv_cnt++;
        if (drdy_cnt > 0) begin
            drdy_cnt--;
            if (drdy_cnt == 0) begin drdy_n = 1'b0; low_cnt = 3; end
        end else if (low_cnt > 0) begin
            low_cnt--;
            if (low_cnt == 0) drdy_n = 1'b1;
        end
        if (cmd_done) begin
            cmd_done = 1'b0;
            busy = 0;
        end else if (busy) begin
            if (lat == 0) begin
                cmd_done = 1'b1;
                if (log_n > 0) log_d[log_n-1] = cyc;
                if (c_op == 2'd1) cmd_rdata = regs[c_code[4:0]];
                if (c_op == 2'd2) regs[c_code[4:0]] = c_wd;
                if (c_op == 2'd0 && c_code == 8'h06) begin
                    for (int i = 0; i < 32; i++) regs[i] = 8'h00;
                    regs[1] = 8'h91; regs[3] = 8'h60;
                    for (int i = 0; i < NCH; i++) regs[5+i] = 8'h18;
                end
                if (c_op == 2'd0 && c_code == 8'h08 && drdy_en) drdy_cnt = 3;
            end else lat--;
        end
        if (!busy && cmd_req) begin
            busy = 1; lat = 1 + ($urandom % 4);
            c_op = cmd_op; c_code = cmd_code; c_wd = cmd_wdata;
            if (log_n < 64) begin
                log_code[log_n] = cmd_code; log_len[log_n] = int'(cmd_len);
                log_t[log_n] = cyc; log_n++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        summary();
    end

    function automatic logic [7:0] exp_code(input int p);
        if (p == 0) return 8'h06;
        if (p == 1) return 8'h11;
        if (p == 2) return 8'h21;
        if (p == 3) return 8'h41;
        if (p == 4) return 8'h23;
        if (p == 5) return 8'h43;
        if (p < 6 + 2 * NCH) return ((p - 6) % 2 == 0) ? 8'(8'h25 + (p - 6) / 2) : 8'(8'h45 + (p - 6) / 2);
        if (p == 6 + 2 * NCH) return 8'h1A;
        if (p == 7 + 2 * NCH) return 8'h08;
        return 8'h0A;
    endfunction

    function automatic int exp_len(input logic [2:0] r);
        return (r <= 3'd1) ? 3 + 2 * NCH : 3 + 3 * NCH;
    endfunction

    function automatic logic [2:0] pick_gain(input int k);
        case (k % 5) 0: return 3'd1; 1: return 3'd2; 2: return 3'd4; 3: return 3'd5; default: return 3'd6; endcase
    endfunction

    function automatic logic [2:0] pick_mux(input int k);
        case (k % 4) 0: return 3'd0; 1: return 3'd1; 2: return 3'd3; default: return 3'd4; endcase
    endfunction

    task automatic pulse_init();
        log_n = 0;
        @(negedge clk); init_req = 1'b1;
        @(negedge clk); init_req = 1'b0;
    endtask

    task automatic expect_reject(input string tag);
        pulse_init();
        repeat (20) @(negedge clk);
        chk(err == 1'b1, tag, err, 1);
        chk(log_n == 0, tag, log_n, 0);
        chk(init_done == 1'b0, tag, init_done, 0);
    endtask

    task automatic run_init_and_check();
        int w = 0, sp;
        pulse_init();
        while (!init_done && !err && w < 3000) begin @(negedge clk); w++; end
        chk(init_done == 1'b1 && err == 1'b0, "R7 init_done", init_done, 1);
        chk(log_n == 2 * NCH + 9, "R2 count", log_n, 2 * NCH + 9);
        for (int p = 0; p < 2 * NCH + 9; p++)
            chk(log_code[p] == exp_code(p), "R2 order", log_code[p], exp_code(p));
        chk(log_t[1] - log_d[0] >= RST_CYC, "R3 reset gap", log_t[1] - log_d[0], RST_CYC);
        sp = 7 + 2 * NCH;
        chk(log_t[sp+1] - log_d[sp] >= CAL_TICKS * TICK_CYC, "R7 cal gap",
            log_t[sp+1] - log_d[sp], CAL_TICKS * TICK_CYC);
        chk(regs[1] == {5'b10010, rate_code}, "R4 rate reg", regs[1], {5'b10010, rate_code});
        if (ref_ext)
            chk(regs[3] == 8'h60, "R5 ref ext", regs[3], 8'h60);
        else
            chk(regs[3] == {2'b11, ref_4v, 5'b00000}, "R5 ref int", regs[3], {2'b11, ref_4v, 5'b00000});
        for (int i = 0; i < NCH; i++)
            chk(regs[5+i] == {~ch_en[i], ch_gain[3*i +: 3], 1'b1, ch_mux[3*i +: 3]}, "R6 channel reg",
                regs[5+i], {~ch_en[i], ch_gain[3*i +: 3], 1'b1, ch_mux[3*i +: 3]});
        chk(int'(frame_len) == exp_len(rate_code), "R8 frame_len", frame_len, exp_len(rate_code));
    endtask

    task automatic run_conv(input string tag);
        int w = 0, c0;
        c0 = conv_cnt; log_n = 0; drdy_en = 1;
        @(negedge clk); conv_req = 1'b1;
        @(negedge clk); conv_req = 1'b0;
        while (conv_cnt == c0 && w < 500) begin @(negedge clk); w++; end
        @(negedge clk);
        chk(conv_cnt == c0 + 1, tag, conv_cnt - c0, 1);
        chk(log_n == 3, tag, log_n, 3);
        chk(log_code[0] == 8'h08 && log_code[1] == 8'h12 && log_code[2] == 8'h0A, tag, log_code[1], 8'h12);
        chk(log_len[1] == int'(frame_len), tag, log_len[1], frame_len);
        chk(err == 1'b0, tag, err, 0);
    endtask

    initial begin
        int seed, w, t0;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        chk(cmd_req == 0 && init_done == 0 && conv_done == 0 && err == 0, "R1 reset outputs",
            {cmd_req, init_done, conv_done, err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cmd_req == 0 && init_done == 0 && err == 0, "R1 idle after reset", {cmd_req, init_done, err}, 0);

        // R10: conversion before bring-up
        @(negedge clk); conv_req = 1'b1;
        @(negedge clk); conv_req = 1'b0;
        repeat (20) @(negedge clk);
        chk(log_n == 0 && conv_cnt == 0, "R10 ignored conv", log_n, 0);

        // R9: illegal codes
        for (int i = 0; i < NCH; i++) begin
            ch_gain[3*i +: 3] = pick_gain(i); ch_mux[3*i +: 3] = pick_mux(i);
        end
        ch_gain[6 +: 3] = 3'd3; expect_reject("R9 gain 3");
        ch_gain[6 +: 3] = 3'd1; ch_mux[3 +: 3] = 3'd2; expect_reject("R9 mux 2");
        ch_mux[3 +: 3] = 3'd1; rate_code = 3'd7; expect_reject("R9 rate 7");
        ch_gain[0 +: 3] = 3'd0; rate_code = 3'd1; expect_reject("R9 gain 0");

        // Directed bring-up: fast rate, internal 4 V reference, two channels off
        ch_gain = {3'd2, 3'd6, 3'd5, 3'd1}; ch_mux = {3'd4, 3'd3, 3'd1, 3'd0};
        ch_en = 4'b0101; rate_code = 3'd1; ref_ext = 0; ref_4v = 1;
        run_init_and_check();
        run_conv("R11 conversion fast rate");

        // R12: timeout when data-ready never falls
        drdy_en = 0; log_n = 0;
        @(negedge clk); conv_req = 1'b1;
        @(negedge clk); conv_req = 1'b0;
        w = 0;
        while (!err && w < 300) begin @(negedge clk); w++; end
        t0 = (log_n > 0) ? log_d[0] : 0;
        chk(err == 1'b1, "R12 err", err, 1);
        chk(cyc - t0 >= TMO_TICKS * TICK_CYC && cyc - t0 <= TMO_TICKS * TICK_CYC + 8,
            "R12 timeout window", cyc - t0, TMO_TICKS * TICK_CYC);
        repeat (10) @(negedge clk);
        chk(log_n == 1, "R12 no frame read", log_n, 1);
        run_conv("R12 recovery conversion");

        // Directed bring-up: slow rate, external reference
        ch_en = 4'b1110; rate_code = 3'd2; ref_ext = 1; ref_4v = 1;
        run_init_and_check();
        run_conv("R11 conversion slow rate");

        // Random legal configurations
        for (int it = 0; it < 6; it++) begin
            for (int i = 0; i < NCH; i++) begin
                ch_gain[3*i +: 3] = pick_gain($urandom % 5);
                ch_mux[3*i +: 3] = pick_mux($urandom % 4);
            end
            ch_en = NCH'($urandom);
            rate_code = 3'($urandom % 7);
            ref_ext = 1'($urandom); ref_4v = 1'($urandom);
            run_init_and_check();
            run_conv("R11 random conversion");
        end
        if (seed == -1) chk(0, "seed", seed, 0);
        summary();
    end
endmodule